// File: doc/BRIEF.md
# Lookup-Table Cluster Upset Scrubber

This block keeps a cluster of small one-bit-wide lookup tables free of single-bit upsets. The cluster has N data tables, K check tables and one overall-parity table. All tables have 2^k entries. The entries that share a table address form one codeword of a single-error-correct, double-error-detect Hamming code. The code therefore runs across the tables, not along a memory word. A sweep visits one table address per clock and takes 2^k clocks for a full pass. At each address it decodes the codeword and flips a single bad bit back in place. When it finds a double upset it leaves the tables alone, raises a sticky flag and records the address. No reload from outside is needed.

The tables are filled through a load port, which writes the data bits of one address and stores the matching check and parity bits. A read port returns the data bits of any address. A fault port lets a test flip chosen bits to model upsets. The sweep can run back to back (online) or once each time a programmable idle interval expires (offline). Two saturating counters record corrections and uncorrectable detections, and a pulse marks the end of each pass. Elaboration stops with an error if N + K + 1 > 2^K.

Top module: `lutsec_scrubber`

## Requirements
- R1: Codeword layout at address a: Hamming position 2^i holds check table i, and data table j holds the j-th position, counting from 3, that is not a power of two. Check table i is the XOR of the data tables whose position has bit i set. The parity table is the XOR of all other bits. In the fault mask and word, bits [N-1:0] are data tables, bits [N+K-1:N] are check tables and bit N+K is parity. A cluster that has only been loaded produces no correction and no error flag.
- R2: With ld_en high at a clock edge, the entries at ld_addr become ld_data plus the derived check and parity bits. rd_data shows the data bits at rd_addr one clock after rd_addr is presented.
- R3: In online mode the sweep handles one address per clock, in ascending order with wrap-around. pass_done pulses for one cycle after the last address, so successive pulses are 2^k cycles apart when nothing pauses the sweep.
- R4: A single flipped data or check bit is restored in place when the sweep reaches its address. fix_pulse goes high for one cycle and fix_count rises by one.
- R5: A zero syndrome with a parity mismatch rewrites only the parity bit and counts as one correction.
- R6: A nonzero syndrome with matching parity changes no table. It sets dbl_flag, which stays set until reset, loads dbl_addr with the address, and raises dbl_count by one for each detection.
- R7: In offline mode, after a pass ends the sweep stays idle for scrub_interval + 1 cycles and then runs one full pass. Successive pass_done pulses are 2^k + scrub_interval + 1 cycles apart.
- R8: A cycle with ld_en or upset_en high does not advance the sweep and makes no correction, so that pass takes one cycle longer.
- R9: fix_count and dbl_count stop at their all-ones value.
- R10: After reset, rd_data, fix_pulse, dbl_flag, dbl_addr, both counters and pass_done are zero, and the sweep starts at address 0 in the idle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scrub_online | input | 1 | 1: continuous sweep, 0: interval-driven sweep |
| scrub_interval | input | IVL_W | Idle cycles minus one between offline passes |
| ld_en | input | 1 | Load strobe |
| ld_addr | input | ADDR_W | Table address to load |
| ld_data | input | N_DATA | One bit per data table |
| upset_en | input | 1 | Fault strobe |
| upset_addr | input | ADDR_W | Table address to disturb |
| upset_mask | input | N_DATA+N_CHECK+1 | Bits to invert, laid out as in R1 |
| rd_addr | input | ADDR_W | Lookup address |
| rd_data | output | N_DATA | Data bits at rd_addr, one cycle later |
| fix_pulse | output | 1 | One-cycle pulse per correction |
| dbl_flag | output | 1 | Sticky uncorrectable flag |
| dbl_addr | output | ADDR_W | Address of the latest uncorrectable detection |
| fix_count | output | CNT_W | Saturating correction count |
| dbl_count | output | CNT_W | Saturating uncorrectable count |
| pass_done | output | 1 | Pulse after the final address of a pass |

## Verification
A bad encoder or syndrome decoder shows up as a fix_pulse or dbl_flag on a cluster that has only been loaded, at the latest one pass (2^k cycles) after the sweep starts. A wrong correction mask changes rd_data at the disturbed address after the next visit. A stuck or skipping sweep address moves or removes the pass_done pulses within one pass. A timer that counts wrong shifts the offline pulse spacing away from 2^k + interval + 1. The reference model runs alongside the block and compares every output on every clock, so the first cycle of any divergence is reported.

// File: rtl/lutsec_pkg.sv
package lutsec_pkg;

  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_FIX  = 2'd1,
    EV_FAIL = 2'd2
  } scrub_ev_e;

  function automatic bit is_pow2(input int q);
    return (q > 0) && ((q & (q - 1)) == 0);
  endfunction

  // Hamming position of data table j: the j-th non-power-of-two index from 3 up
  function automatic int data_pos(input int j);
    int r;
    int c;
    r = 0;
    c = 0;
    for (int q = 3; q < j + 40; q++) begin
      if (!is_pow2(q)) begin
        if (c == j && r == 0) r = q;
        c++;
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/lutsec_encoder.sv
module lutsec_encoder #(
  parameter int N = 4,
  parameter int K = 3
) (
  input  logic [N-1:0] data,
  output logic [K-1:0] chk
);
  // check bit i covers every data position whose index has bit i set
  always_comb begin
    for (int i = 0; i < K; i++) begin
      chk[i] = 1'b0;
      for (int j = 0; j < N; j++) begin
        if (((lutsec_pkg::data_pos(j) >> i) & 1) != 0) chk[i] = chk[i] ^ data[j];
      end
    end
  end
endmodule

// File: rtl/lutsec_decoder.sv
module lutsec_decoder #(
  parameter int N = 4,
  parameter int K = 3
) (
  input  logic [N+K:0]          word,
  output logic [N+K:0]          fix_mask,
  output lutsec_pkg::scrub_ev_e ev
);
  logic [K-1:0] recomp;
  logic [K-1:0] syn;
  logic         par_err;
  logic [N+K:0] loc;

  lutsec_encoder #(.N(N), .K(K)) u_enc (
    .data (word[N-1:0]),
    .chk  (recomp)
  );

  assign syn     = recomp ^ word[N+K-1:N];
  assign par_err = ^word;

  always_comb begin
    loc = '0;
    for (int i = 0; i < K; i++) begin
      if (syn == K'(1 << i)) loc[N+i] = 1'b1;
    end
    for (int j = 0; j < N; j++) begin
      if (syn == K'(lutsec_pkg::data_pos(j))) loc[j] = 1'b1;
    end

    fix_mask = '0;
    ev       = lutsec_pkg::EV_NONE;
    if (syn == '0) begin
      if (par_err) begin
        fix_mask[N+K] = 1'b1;
        ev            = lutsec_pkg::EV_FIX;
      end
    end else if (par_err && (|loc)) begin
      fix_mask = loc;
      ev       = lutsec_pkg::EV_FIX;
    end else begin
      ev = lutsec_pkg::EV_FAIL;
    end
  end
endmodule

// File: rtl/lutsec_store.sv
module lutsec_store #(
  parameter int W  = 8,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic [AW-1:0] ra_scrub,
  input  logic [AW-1:0] ra_upset,
  input  logic [AW-1:0] ra_look,
  output logic [W-1:0]  rd_scrub,
  output logic [W-1:0]  rd_upset,
  output logic [W-1:0]  rd_look
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
  end

  assign rd_scrub = mem[ra_scrub];
  assign rd_upset = mem[ra_upset];
  assign rd_look  = mem[ra_look];
endmodule

// File: rtl/lutsec_sweep.sv
module lutsec_sweep #(
  parameter int AW = 4,
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          online,
  input  logic [IW-1:0] interval,
  input  logic          hold,
  output logic [AW-1:0] addr,
  output logic          step,
  output logic          last
);
  localparam logic [AW-1:0] LAST_A = '1;

  logic          busy;
  logic [IW-1:0] idle;

  assign step = !rst && (online || busy) && !hold;
  assign last = step && (addr == LAST_A);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr <= '0;
      busy <= 1'b0;
      idle <= '0;
    end else begin
      if (step) begin
        addr <= addr + AW'(1);
        if (addr == LAST_A) busy <= 1'b0;
      end
      if (online) begin
        idle <= '0;
      end else if (!busy) begin
        if (idle == interval) begin
          busy <= 1'b1;
          idle <= '0;
        end else begin
          idle <= idle + IW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/lutsec_scrubber.sv
module lutsec_scrubber #(
  parameter int N_DATA  = 4,
  parameter int N_CHECK = 3,
  parameter int ADDR_W  = 4,
  parameter int IVL_W   = 16,
  parameter int CNT_W   = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      scrub_online,
  input  logic [IVL_W-1:0]          scrub_interval,
  input  logic                      ld_en,
  input  logic [ADDR_W-1:0]         ld_addr,
  input  logic [N_DATA-1:0]         ld_data,
  input  logic                      upset_en,
  input  logic [ADDR_W-1:0]         upset_addr,
  input  logic [N_DATA+N_CHECK:0]   upset_mask,
  input  logic [ADDR_W-1:0]         rd_addr,
  output logic [N_DATA-1:0]         rd_data,
  output logic                      fix_pulse,
  output logic                      dbl_flag,
  output logic [ADDR_W-1:0]         dbl_addr,
  output logic [CNT_W-1:0]          fix_count,
  output logic [CNT_W-1:0]          dbl_count,
  output logic                      pass_done
);
  import lutsec_pkg::*;

  localparam int WORD_W = N_DATA + N_CHECK + 1;

  if (N_DATA + N_CHECK + 1 > (1 << N_CHECK)) begin : g_bound_violated
    $error("check table count too small for the data table count");
  end

  logic              sweep_hold;
  logic [ADDR_W-1:0] sweep_addr;
  logic              sweep_step;
  logic              sweep_last;
  logic [WORD_W-1:0] scrub_word;
  logic [WORD_W-1:0] upset_word;
  logic [WORD_W-1:0] look_word;
  logic [WORD_W-1:0] fix_mask;
  scrub_ev_e         ev;
  logic [N_CHECK-1:0] ld_chk;
  logic              st_we;
  logic [ADDR_W-1:0] st_wa;
  logic [WORD_W-1:0] st_wd;

  assign sweep_hold = ld_en || upset_en;

  lutsec_sweep #(.AW(ADDR_W), .IW(IVL_W)) u_sweep (
    .clk      (clk),
    .rst      (rst),
    .online   (scrub_online),
    .interval (scrub_interval),
    .hold     (sweep_hold),
    .addr     (sweep_addr),
    .step     (sweep_step),
    .last     (sweep_last)
  );

  lutsec_encoder #(.N(N_DATA), .K(N_CHECK)) u_ld_enc (
    .data (ld_data),
    .chk  (ld_chk)
  );

  lutsec_decoder #(.N(N_DATA), .K(N_CHECK)) u_dec (
    .word     (scrub_word),
    .fix_mask (fix_mask),
    .ev       (ev)
  );

  // one write port: load, then fault, then in-place correction
  always_comb begin
    st_we = 1'b0;
    st_wa = sweep_addr;
    st_wd = scrub_word ^ fix_mask;
    if (ld_en) begin
      st_we = 1'b1;
      st_wa = ld_addr;
      st_wd = {^{ld_chk, ld_data}, ld_chk, ld_data};
    end else if (upset_en) begin
      st_we = 1'b1;
      st_wa = upset_addr;
      st_wd = upset_word ^ upset_mask;
    end else if (sweep_step && ev == EV_FIX) begin
      st_we = 1'b1;
    end
  end

  lutsec_store #(.W(WORD_W), .AW(ADDR_W)) u_store (
    .clk      (clk),
    .we       (st_we),
    .wa       (st_wa),
    .wd       (st_wd),
    .ra_scrub (sweep_addr),
    .ra_upset (upset_addr),
    .ra_look  (rd_addr),
    .rd_scrub (scrub_word),
    .rd_upset (upset_word),
    .rd_look  (look_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data   <= '0;
      fix_pulse <= 1'b0;
      dbl_flag  <= 1'b0;
      dbl_addr  <= '0;
      fix_count <= '0;
      dbl_count <= '0;
      pass_done <= 1'b0;
    end else begin
      rd_data   <= look_word[N_DATA-1:0];
      pass_done <= sweep_last;
      fix_pulse <= sweep_step && (ev == EV_FIX);
      if (sweep_step && ev == EV_FIX && !(&fix_count)) fix_count <= fix_count + CNT_W'(1);
      if (sweep_step && ev == EV_FAIL) begin
        dbl_flag <= 1'b1;
        dbl_addr <= sweep_addr;
        if (!(&dbl_count)) dbl_count <= dbl_count + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/lutsec_scrubber_chk.sv
module lutsec_scrubber_chk #(
  parameter int AW = 4,
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          hold,
  input logic [AW-1:0] sw_addr,
  input logic          fix_pulse,
  input logic [CW-1:0] fix_count,
  input logic [CW-1:0] dbl_count,
  input logic          dbl_flag,
  input logic          pass_done
);
  p_fix_counted_r4: assert property (@(posedge clk) disable iff (rst)
    fix_pulse |-> ((fix_count != $past(fix_count)) || (&fix_count)));

  p_flag_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    dbl_flag |=> dbl_flag);

  p_dbl_monotone_r6: assert property (@(posedge clk) disable iff (rst)
    !(dbl_count < $past(dbl_count)));

  p_done_single_r3: assert property (@(posedge clk) disable iff (rst)
    pass_done |=> !pass_done);

  p_hold_freezes_r8: assert property (@(posedge clk) disable iff (rst)
    hold |=> $stable(sw_addr));

  p_fix_saturate_r9: assert property (@(posedge clk) disable iff (rst)
    (&fix_count) |=> (&fix_count));

  p_dbl_saturate_r9: assert property (@(posedge clk) disable iff (rst)
    (&dbl_count) |=> (&dbl_count));

  p_reset_clear_r10: assert property (@(posedge clk)
    rst |=> (fix_count == '0 && dbl_count == '0 && !dbl_flag && !pass_done));
endmodule

bind lutsec_scrubber lutsec_scrubber_chk #(.AW(ADDR_W), .CW(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .hold      (sweep_hold),
  .sw_addr   (sweep_addr),
  .fix_pulse (fix_pulse),
  .fix_count (fix_count),
  .dbl_count (dbl_count),
  .dbl_flag  (dbl_flag),
  .pass_done (pass_done)
);

// File: tb/tb_lutsec_scrubber.sv
module tb_lutsec_scrubber;
  localparam int N = 4;
  localparam int K = 3;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;
  localparam int W = N + K + 1;
  localparam int CW = 8;
  localparam int IW = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst = 1'b1;
  logic          scrub_online = 1'b0;
  logic [IW-1:0] scrub_interval = '1;
  logic          ld_en = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [N-1:0]  ld_data = '0;
  logic          upset_en = 1'b0;
  logic [AW-1:0] upset_addr = '0;
  logic [W-1:0]  upset_mask = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [N-1:0]  rd_data;
  logic          fix_pulse, dbl_flag, pass_done;
  logic [AW-1:0] dbl_addr;
  logic [CW-1:0] fix_count, dbl_count;

  lutsec_scrubber #(.N_DATA(N), .N_CHECK(K), .ADDR_W(AW), .IVL_W(IW), .CNT_W(CW)) dut (
    .clk(clk), .rst(rst), .scrub_online(scrub_online), .scrub_interval(scrub_interval),
    .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .upset_en(upset_en), .upset_addr(upset_addr), .upset_mask(upset_mask),
    .rd_addr(rd_addr), .rd_data(rd_data), .fix_pulse(fix_pulse), .dbl_flag(dbl_flag),
    .dbl_addr(dbl_addr), .fix_count(fix_count), .dbl_count(dbl_count), .pass_done(pass_done)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int last_done = 0;
  int last_gap = 0;
  bit loaded = 0;
  logic [N-1:0] gold [DEPTH];

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [W-1:0] mw [DEPTH];
  int m_addr, m_idle, m_corr, m_unc, m_daddr;
  bit m_busy, m_single, m_dbl, m_done;
  logic [N-1:0] m_rd;

  function automatic bit pw2(input int p);
    return (p > 0) && ((p & (p - 1)) == 0);
  endfunction

  // bit index in the word for Hamming position p (p >= 1)
  function automatic int bit_of_pos(input int p);
    int d;
    int lg;
    d = 0;
    for (int q = 1; q < p; q++) if (!pw2(q)) d++;
    if (pw2(p)) begin
      lg = 0;
      while ((1 << lg) != p) lg++;
      return N + lg;
    end
    return d;
  endfunction

  function automatic logic [W-1:0] m_encode(input logic [N-1:0] d);
    logic [W-1:0] w;
    int s;
    w = '0;
    w[N-1:0] = d;
    s = 0;
    for (int p = 1; p <= N + K; p++) if (!pw2(p) && w[bit_of_pos(p)]) s = s ^ p;
    for (int i = 0; i < K; i++) w[N+i] = s[i];
    w[N+K] = ^w[N+K-1:0];
    return w;
  endfunction

  always @(posedge clk) begin
    bit act, old_busy;
    int s, kind, fb;
    logic [W-1:0] w;
    if (rst) begin
      m_addr = 0; m_idle = 0; m_busy = 0; m_corr = 0; m_unc = 0; m_daddr = 0;
      m_single = 0; m_dbl = 0; m_done = 0; m_rd = '0;
    end else begin
      old_busy = m_busy;
      act = (scrub_online || m_busy) && !(ld_en || upset_en);
      m_rd = mw[rd_addr][N-1:0];
      m_single = 0;
      m_done = 0;
      if (act) begin
        w = mw[m_addr];
        s = 0;
        for (int p = 1; p <= N + K; p++) if (w[bit_of_pos(p)]) s = s ^ p;
        kind = 0; fb = 0;
        if (s == 0 && (^w)) begin kind = 1; fb = N + K; end
        else if (s != 0 && (^w) && s <= N + K) begin kind = 1; fb = bit_of_pos(s); end
        else if (s != 0) kind = 2;
        if (kind == 1) begin
          mw[m_addr][fb] = ~mw[m_addr][fb];
          m_single = 1;
          if (m_corr < (1 << CW) - 1) m_corr++;
        end else if (kind == 2) begin
          m_dbl = 1;
          m_daddr = m_addr;
          if (m_unc < (1 << CW) - 1) m_unc++;
        end
        if (m_addr == DEPTH - 1) begin m_done = 1; m_busy = 0; end
        m_addr = (m_addr + 1) % DEPTH;
      end
      if (scrub_online) m_idle = 0;
      else if (!old_busy) begin
        if (m_idle == int'(scrub_interval)) begin m_busy = 1; m_idle = 0; end
        else m_idle++;
      end
      if (ld_en) mw[ld_addr] = m_encode(ld_data);
      else if (upset_en) mw[upset_addr] = mw[upset_addr] ^ upset_mask;
    end
    cyc++;
    #1;
    if (loaded) check("R2 rd_data vs model", int'(rd_data), int'(m_rd));
    check("R4 fix_pulse vs model", int'(fix_pulse), int'(m_single));
    check("R6 dbl_flag vs model", int'(dbl_flag), int'(m_dbl));
    check("R6 dbl_addr vs model", int'(dbl_addr), m_daddr);
    check("R9 fix_count vs model", int'(fix_count), m_corr);
    check("R9 dbl_count vs model", int'(dbl_count), m_unc);
    check("R3 pass_done vs model", int'(pass_done), int'(m_done));
    if (pass_done) begin
      last_gap = cyc - last_done;
      last_done = cyc;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic do_load(input int a, input logic [N-1:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_addr = AW'(a); ld_data = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic do_upset(input int a, input logic [W-1:0] m);
    @(negedge clk);
    upset_en = 1'b1; upset_addr = AW'(a); upset_mask = m;
    @(negedge clk);
    upset_en = 1'b0;
  endtask

  task automatic wait_done();
    do begin
      @(posedge clk);
      #1;
    end while (!pass_done);
  endtask

  task automatic read_check(input string req, input int a, input int exp);
    @(negedge clk);
    rd_addr = AW'(a);
    @(posedge clk);
    #2;
    check(req, int'(rd_data), exp);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    int a, a2, b1, b2, fixes;
    logic [W-1:0] m2;
    for (int i = 0; i < DEPTH; i++) mw[i] = '0;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 rd_data after reset", int'(rd_data), 0);
    check("R10 fix_pulse after reset", int'(fix_pulse), 0);
    check("R10 dbl_flag after reset", int'(dbl_flag), 0);
    check("R10 dbl_addr after reset", int'(dbl_addr), 0);
    check("R10 fix_count after reset", int'(fix_count), 0);
    check("R10 dbl_count after reset", int'(dbl_count), 0);
    check("R10 pass_done after reset", int'(pass_done), 0);
    rst = 1'b0;

    // R2: load every address while offline and idle
    for (int i = 0; i < DEPTH; i++) begin
      gold[i] = N'($urandom);
      do_load(i, gold[i]);
    end
    @(negedge clk);
    loaded = 1;
    for (int i = 0; i < DEPTH; i++) read_check("R2 readback after load", i, int'(gold[i]));

    // R1, R3: clean online sweep
    @(negedge clk);
    scrub_online = 1'b1;
    wait_done();
    wait_done();
    check("R3 online pass spacing", last_gap, DEPTH);
    check("R1 no correction on clean cluster", int'(fix_count), 0);
    check("R1 no double flag on clean cluster", int'(dbl_flag), 0);

    // R4: data table upset
    a = $urandom % DEPTH;
    do_upset(a, W'(1) << ($urandom % N));
    wait_done(); wait_done();
    read_check("R4 data bit restored", a, int'(gold[a]));
    check("R4 fix_count after data upset", int'(fix_count), 1);

    // R4: check table upset
    a = $urandom % DEPTH;
    do_upset(a, W'(1) << (N + ($urandom % K)));
    wait_done(); wait_done();
    read_check("R4 data intact after check upset", a, int'(gold[a]));
    check("R4 fix_count after check upset", int'(fix_count), 2);

    // R5: parity table upset
    a = $urandom % DEPTH;
    do_upset(a, W'(1) << (N + K));
    wait_done(); wait_done();
    read_check("R5 data intact after parity upset", a, int'(gold[a]));
    check("R5 fix_count after parity upset", int'(fix_count), 3);

    // R8: a load inside a pass stretches it by one cycle
    wait_done();
    repeat (5) @(negedge clk);
    a = $urandom % DEPTH;
    do_load(a, gold[a]);
    wait_done();
    check("R8 pass spacing with one load", last_gap, DEPTH + 1);

    // R4: random single upsets over all tables
    fixes = 3;
    for (int it = 0; it < 20; it++) begin
      a = $urandom % DEPTH;
      do_upset(a, W'(1) << ($urandom % W));
      fixes++;
      wait_done(); wait_done();
      read_check("R4 random single upset restored", a, int'(gold[a]));
    end
    check("R4 fix_count after random upsets", int'(fix_count), fixes);

    // R7: offline interval
    @(negedge clk);
    scrub_online = 1'b0;
    scrub_interval = 16'd5;
    wait_done(); wait_done();
    check("R7 offline pass spacing", last_gap, DEPTH + 5 + 1);

    // R6: double upset
    @(negedge clk);
    scrub_online = 1'b1;
    a2 = $urandom % DEPTH;
    b1 = $urandom % W;
    b2 = (b1 + 1 + ($urandom % (W - 1))) % W;
    m2 = (W'(1) << b1) | (W'(1) << b2);
    do_upset(a2, m2);
    wait_done(); wait_done();
    check("R6 dbl_flag set", int'(dbl_flag), 1);
    check("R6 dbl_addr recorded", int'(dbl_addr), a2);
    check("R6 fix_count unchanged by double", int'(fix_count), fixes);
    read_check("R6 tables left unchanged", a2, int'(gold[a2] ^ m2[N-1:0]));

    // R9: saturation under repeated detections
    repeat (300) wait_done();
    check("R9 dbl_count saturated", int'(dbl_count), (1 << CW) - 1);
    check("R6 dbl_flag still set", int'(dbl_flag), 1);

    // reload the bad address, flag remains, counter stays at limit
    do_load(a2, gold[a2]);
    wait_done(); wait_done();
    read_check("R2 reload clears double", a2, int'(gold[a2]));
    check("R9 dbl_count held", int'(dbl_count), (1 << CW) - 1);
    check("R6 flag sticky after reload", int'(dbl_flag), 1);

    finish_run();
  end
endmodule